// File: doc/BRIEF.md
# Programmable Half-Period Divider with Toggled Output

This block divides a stream of count events down to a square wave. An 8-bit down counter is loaded with a reload word. Each count event moves it one step lower. When it has run out, the next event reloads it and inverts a single output bit. The output half-period, measured in count events, therefore equals the reload word, and a reload word of zero gives 256. Typical uses are the slowly alternating frame-inversion drive of a passive liquid-crystal panel and general clock division.

Count events arrive as two strobe inputs, both sampled by one system clock. One strobe stands in for a rising-edge count clock and the other for a falling-edge count clock. A cycle in which either strobe is high is one count event. An active-low load input makes the next count event copy the reload word into the counter. Two active-low controls force the output stage on the system clock and leave the counter alone. Clear drives the output high and preset drives it low. Next to the square wave, a one-cycle terminal pulse marks every reload-and-invert event.

Top module: `frame_inv_divider`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wave_out` is 0 and `tc_pulse` is 0.
- R2: A count event is a system-clock cycle in which `strobe_rise` or `strobe_fall` is high. In a cycle with neither strobe high, the counter does not change.
- R3: A count event with `load_n` low copies `reload_val` into the counter. It gives no terminal pulse and leaves `wave_out` unchanged, even when the counter held zero.
- R4: In steady counting with a reload word R from 1 to 255, consecutive terminal events are exactly R count events apart.
- R5: With a reload word of 0, consecutive terminal events are 256 count events apart.
- R6: After a load of a nonzero word R, the first terminal event is the (R+1)th count event. After a load of 0, the first count event moves the counter to 255 without a terminal event, and the first terminal event is the 257th count event.
- R7: On a terminal event, `tc_pulse` is high in the next cycle. In that same cycle `wave_out` holds the inverse of its previous value, unless clear or preset is active.
- R8: A cycle with `clr_n` low and `pst_n` high sets `wave_out` to 1 in the next cycle.
- R9: A cycle with `pst_n` low sets `wave_out` to 0 in the next cycle. Preset wins when `clr_n` is also low.
- R10: Clear and preset have no effect on the counter. The spacing of terminal events is unchanged by them.
- R11: With `clr_n` and `pst_n` high, `wave_out` changes only in the cycle after a terminal event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_rise | input | 1 | Count strobe standing in for the rising-edge count clock |
| strobe_fall | input | 1 | Count strobe standing in for the falling-edge count clock |
| reload_val | input | 8 | Reload word (half-period; 0 means 256) |
| load_n | input | 1 | Active-low synchronous load of the reload word |
| clr_n | input | 1 | Active-low output clear (forces output high) |
| pst_n | input | 1 | Active-low output preset (forces output low, wins over clear) |
| wave_out | output | 1 | Toggled square-wave output |
| tc_pulse | output | 1 | One-cycle pulse after each terminal event |

## Verification
The divider runs with reload words 1, 2, 255 and 0. For each word the bench measures the first interval after a load and a following steady interval. The two measurements separate the plus-one delay after a load from the exact steady half-period, and the zero case separates the 256 wrap from an immediate re-trigger. Count events come through the rising strobe, the falling strobe and both strobes together, with idle cycles in between. A design that ignores one strobe, double-counts a cycle with both strobes high, or counts idle cycles shows a wrong interval. A load in the middle of a count, a load while the counter holds zero, and clear and preset pulses during a count each have their own scenario. Together these show that loading wins over the terminal action and that the output controls leave the counter's timing alone.

// File: rtl/fid_pkg.sv
package fid_pkg;
   // Which count strobes are honoured
   typedef enum logic [1:0] {
      FID_EDGE_BOTH = 2'd0,
      FID_EDGE_RISE = 2'd1,
      FID_EDGE_FALL = 2'd2
   } fid_edge_e;

   // Counter action chosen for a cycle
   typedef enum logic [1:0] {
      FID_ACT_HOLD   = 2'd0,
      FID_ACT_LOAD   = 2'd1,
      FID_ACT_WRAP   = 2'd2,
      FID_ACT_STEP   = 2'd3
   } fid_act_e;
endpackage

// File: rtl/fid_strobe_merge.sv
module fid_strobe_merge
   import fid_pkg::*;
#(
   parameter fid_edge_e EDGE_MODE = FID_EDGE_BOTH
) (
   input  logic strobe_rise,
   input  logic strobe_fall,
   output logic cnt_en
);
   generate
      if (EDGE_MODE == FID_EDGE_BOTH) begin : g_both
         assign cnt_en = strobe_rise | strobe_fall;
      end else if (EDGE_MODE == FID_EDGE_RISE) begin : g_rise
         logic unused_fall;
         assign unused_fall = strobe_fall;
         assign cnt_en = strobe_rise;
      end else begin : g_fall
         logic unused_rise;
         assign unused_rise = strobe_rise;
         assign cnt_en = strobe_fall;
      end
   endgenerate
endmodule

// File: rtl/fid_down_counter.sv
module fid_down_counter
   import fid_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_en,
   input  logic             load_n,
   input  logic [CNT_W-1:0] reload,
   output logic             term_fire,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   fid_act_e   act;
   logic       fresh_q;   // set after a load of zero: skip the terminal check once
   logic       at_zero;

   assign at_zero = (cnt_q == ZERO);

   always_comb begin
      if (!cnt_en)                 act = FID_ACT_HOLD;
      else if (!load_n)            act = FID_ACT_LOAD;
      else if (at_zero && !fresh_q) act = FID_ACT_WRAP;
      else                         act = FID_ACT_STEP;
   end

   assign term_fire = (act == FID_ACT_WRAP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= ZERO;
         fresh_q <= 1'b0;
      end else begin
         case (act)
            FID_ACT_LOAD: begin
               cnt_q   <= reload;
               fresh_q <= (reload == ZERO);
            end
            FID_ACT_WRAP: begin
               // the terminal event also counts as the first step of the new period
               cnt_q   <= reload - ONE;
               fresh_q <= 1'b0;
            end
            FID_ACT_STEP: begin
               cnt_q   <= cnt_q - ONE;
               fresh_q <= 1'b0;
            end
            default: begin
               cnt_q   <= cnt_q;
               fresh_q <= fresh_q;
            end
         endcase
      end
   end

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(cnt_q));

   assert_load_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load_n) |=> (cnt_q == $past(reload)));

   assert_zero_load_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load_n && reload == ZERO) ##1 (cnt_en && load_n) |=> (cnt_q == {CNT_W{1'b1}}));
endmodule

// File: rtl/fid_toggle_stage.sv
module fid_toggle_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic term_fire,
   input  logic clr_n,
   input  logic pst_n,
   output logic wave_q,
   output logic tc_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
         tc_q   <= 1'b0;
      end else begin
         tc_q <= term_fire;
         if (!pst_n)          wave_q <= 1'b0;
         else if (!clr_n)     wave_q <= 1'b1;
         else if (term_fire)  wave_q <= ~wave_q;
      end
   end

   assert_preset_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !pst_n |=> !wave_q);

   assert_clear_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pst_n && !clr_n) |=> wave_q);

   assert_quiet_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pst_n && clr_n && !term_fire) |=> $stable(wave_q));
endmodule

// File: rtl/frame_inv_divider.sv
module frame_inv_divider
   import fid_pkg::*;
#(
   parameter int unsigned CNT_W     = 8,
   parameter fid_edge_e   EDGE_MODE = FID_EDGE_BOTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe_rise,
   input  logic             strobe_fall,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             load_n,
   input  logic             clr_n,
   input  logic             pst_n,
   output logic             wave_out,
   output logic             tc_pulse
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("frame_inv_divider: CNT_W must be 2..32");
      end
   endgenerate

   logic             cnt_en;
   logic             term_fire;
   logic [CNT_W-1:0] cnt_q;

   fid_strobe_merge #(.EDGE_MODE(EDGE_MODE)) u_merge (
      .strobe_rise (strobe_rise),
      .strobe_fall (strobe_fall),
      .cnt_en      (cnt_en)
   );

   fid_down_counter #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_en    (cnt_en),
      .load_n    (load_n),
      .reload    (reload_val),
      .term_fire (term_fire),
      .cnt_q     (cnt_q)
   );

   fid_toggle_stage u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .term_fire (term_fire),
      .clr_n     (clr_n),
      .pst_n     (pst_n),
      .wave_q    (wave_out),
      .tc_q      (tc_pulse)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!wave_out && !tc_pulse));

   assert_tc_inverts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_pulse && $past(pst_n) && $past(clr_n)) |-> (wave_out != $past(wave_out)));

   assert_controls_keep_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && (!clr_n || !pst_n)) |=> $stable(cnt_q));
endmodule

// File: tb/frame_inv_divider_tb.sv
module frame_inv_divider_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe_rise = 1'b0;
   logic       strobe_fall = 1'b0;
   logic [7:0] reload_val = 8'd0;
   logic       load_n = 1'b1;
   logic       clr_n = 1'b1;
   logic       pst_n = 1'b1;
   logic       wave_out;
   logic       tc_pulse;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_inv_divider u_dut (
      .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise), .strobe_fall(strobe_fall),
      .reload_val(reload_val), .load_n(load_n), .clr_n(clr_n), .pst_n(pst_n),
      .wave_out(wave_out), .tc_pulse(tc_pulse)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive inputs at a falling edge, let one rising edge pass, sample at the next falling edge
   task automatic step(input logic r, input logic f);
      strobe_rise = r;
      strobe_fall = f;
      @(negedge clk);
      strobe_rise = 1'b0;
      strobe_fall = 1'b0;
   endtask

   task automatic do_load(input logic [7:0] val);
      reload_val = val;
      load_n = 1'b0;
      step(1'b1, 1'b0);
      load_n = 1'b1;
   endtask

   // Issues count events in varied strobe patterns; returns the event index of the first terminal
   task automatic count_to_tc(input string req, output int idx);
      logic prev;
      idx = -1;
      for (int i = 1; i <= 300; i++) begin
         if (i % 3 == 0) begin
            prev = wave_out;
            step(1'b0, 1'b0);
            if (tc_pulse) check({req, " idle gave tc"}, 1, 0);
            if (wave_out != prev) check("R11 idle wave stable", int'(wave_out), int'(prev));
         end
         prev = wave_out;
         case (i % 4)
            0: step(1'b1, 1'b0);
            1: step(1'b0, 1'b1);
            2: step(1'b1, 1'b1);
            default: step(1'b0, 1'b1);
         endcase
         if (tc_pulse) begin
            check("R7 wave inverts on tc", int'(wave_out), int'(!prev));
            idx = i;
            break;
         end else if (wave_out != prev) begin
            check("R11 wave stable between tc", int'(wave_out), int'(prev));
         end
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 wave in reset", int'(wave_out), 0);
      check("R1 tc in reset", int'(tc_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 wave after reset", int'(wave_out), 0);
      check("R1 tc after reset", int'(tc_pulse), 0);
   endtask

   task automatic t_sweep(input logic [7:0] r);
      int first_exp, steady_exp, got;
      first_exp  = (r == 0) ? 257 : int'(r) + 1;
      steady_exp = (r == 0) ? 256 : int'(r);
      do_load(r);
      check("R3 no tc on load", int'(tc_pulse), 0);
      count_to_tc("R6", got);
      check("R6 first interval after load", got, first_exp);
      count_to_tc("R4", got);
      check((r == 0) ? "R5 steady interval for 0" : "R4 steady interval", got, steady_exp);
      count_to_tc("R4", got);
      check((r == 0) ? "R5 second interval for 0" : "R4 second interval", got, steady_exp);
   endtask

   task automatic t_idle;
      int got;
      do_load(8'd3);
      repeat (20) begin
         step(1'b0, 1'b0);
         if (tc_pulse) check("R2 idle tc", 1, 0);
      end
      count_to_tc("R2", got);
      check("R2 idle cycles do not count", got, 4);
   endtask

   task automatic t_load_override;
      int got;
      logic w;
      do_load(8'd5);
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      w = wave_out;
      do_load(8'd7);
      check("R3 mid-count load no tc", int'(tc_pulse), 0);
      count_to_tc("R3", got);
      check("R3 reload restarts count", got, 8);
      do_load(8'd1);
      step(1'b1, 1'b0);           // counter now holds zero
      w = wave_out;
      do_load(8'd2);              // load wins over the terminal action
      check("R3 load at zero no tc", int'(tc_pulse), 0);
      check("R3 load at zero wave kept", int'(wave_out), int'(w));
      count_to_tc("R3", got);
      check("R3 count after load at zero", got, 3);
   endtask

   task automatic t_controls;
      int got;
      pst_n = 1'b0; step(1'b0, 1'b0); pst_n = 1'b1;
      check("R9 preset forces low", int'(wave_out), 0);
      clr_n = 1'b0; step(1'b0, 1'b0); clr_n = 1'b1;
      check("R8 clear forces high", int'(wave_out), 1);
      clr_n = 1'b0; pst_n = 1'b0; step(1'b0, 1'b0); clr_n = 1'b1; pst_n = 1'b1;
      check("R9 preset wins over clear", int'(wave_out), 0);
      do_load(8'd4);
      step(1'b1, 1'b0);
      step(1'b0, 1'b1);
      clr_n = 1'b0; step(1'b0, 1'b0); clr_n = 1'b1;
      check("R8 clear mid-count", int'(wave_out), 1);
      pst_n = 1'b0; step(1'b0, 1'b0); clr_n = 1'b0; step(1'b0, 1'b0); clr_n = 1'b1; pst_n = 1'b1;
      check("R9 preset mid-count", int'(wave_out), 0);
      clr_n = 1'b0; step(1'b0, 1'b0); clr_n = 1'b1;
      count_to_tc("R10", got);
      check("R10 controls leave count intact", got, 3);
      check("R10 wave after tc from cleared", int'(wave_out), 0);
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_idle();
      t_sweep(8'd1);
      t_sweep(8'd2);
      t_sweep(8'd255);
      t_sweep(8'd0);
      t_load_override();
      t_controls();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule